// File: doc/BRIEF.md
# Sector-Erase Flash Array Controller

This block is a behavioural model of an on-chip flash array behind a small command interface. Storage is arranged as 16-bit words grouped into 1024-byte sectors, 512 words each. An erase always sets every word of one whole sector to all ones. A program writes one word, and only into a word that still holds the erased pattern. No bits are ever merged into an already written word, so changing stored data means erasing the whole sector and writing all of it again.

Software runs an operation in three steps. It loads a word address and a data word, then loads a command code, then strobes the launch input. While the operation is in progress the block holds a busy flag for a fixed number of cycles. The array only changes in the cycle in which busy drops. Any load, command or launch that arrives while busy is dropped and raises a sticky violation flag. A launch that cannot be carried out, either because the program target is not erased or because the code is unknown, raises an access error and leaves the array as it was. A registered read port is always available. While busy, a read from the sector under operation returns all ones.

Top module: `sector_flash`

## Requirements
- R1: After reset, `busy`, `acc_err` and `cmd_viol` are all 0.
- R2: Launching command code 0x40 sets every one of the 512 words in the sector that holds the loaded word address to 0xFFFF. The sector index is word address bits [ADDR_W-1:9].
- R3: An erase or a program leaves every word outside its target, including the words of neighbouring sectors, unchanged.
- R4: Launching command code 0x20 on a word that reads 0xFFFF stores the loaded data word at the loaded word address.
- R5: Launching 0x20 on a word that is not 0xFFFF sets `acc_err` in the next cycle and does not raise `busy`. The stored word keeps its old value, with no bits merged.
- R6: An accepted launch raises `busy` in the next cycle and holds it for exactly OP_CYCLES cycles. The array update takes effect at the same edge where `busy` falls.
- R7: `rd_data` shows the word at `rd_addr` one cycle after it is presented. If `busy` is 1 and `rd_addr` lies in the sector under operation, it shows 0xFFFF instead.
- R8: `ld_valid`, `cmd_valid` or `launch` asserted while `busy` is 1 changes no stored address, data or command and sets `cmd_viol`. `cmd_viol` stays set until `viol_clr` is 1 in a cycle with no new violation.
- R9: A launch with a command code other than 0x20 or 0x40 sets `acc_err` and starts nothing. Each later launch that is not busy recomputes `acc_err`, so an accepted operation clears it.
- R10: The loaded command is consumed by each launch. A second launch with no new command is treated as an unknown code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Load target address and data word |
| ld_addr | input | ADDR_W | Target word address |
| ld_data | input | 16 | Data word for a program |
| cmd_valid | input | 1 | Load command code |
| cmd_code | input | 8 | Command code: 0x20 program, 0x40 sector erase |
| launch | input | 1 | Start the loaded command |
| viol_clr | input | 1 | Write-one clear of `cmd_viol` |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | 16 | Registered read data |
| busy | output | 1 | Operation in progress |
| acc_err | output | 1 | Last launch was refused |
| cmd_viol | output | 1 | Sticky flag for input received while busy |

## Verification
The properties assume that every address presented is inside the array and that inputs are steady around each rising edge. They also assume that the erase and program work is only ever started through the launch strobe. The stimulus changes inputs only on falling edges and raises at most one step strobe per cycle. It keeps every address below the array size and lets operations run to completion, except where it deliberately injects strobes while busy to test the violation path.

// File: rtl/sflash_pkg.sv
package sflash_pkg;
  localparam int unsigned WORD_W           = 16;
  localparam int unsigned SECTOR_BYTES     = 1024;
  localparam int unsigned WORDS_PER_SECTOR = SECTOR_BYTES / (WORD_W / 8);
  localparam int unsigned SECT_SHIFT       = $clog2(WORDS_PER_SECTOR);
  localparam int unsigned CODE_W           = 8;

  localparam logic [CODE_W-1:0] CODE_NONE  = 8'h00;
  localparam logic [CODE_W-1:0] CODE_PROG  = 8'h20;
  localparam logic [CODE_W-1:0] CODE_ERASE = 8'h40;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2
  } op_e;
endpackage

// File: rtl/sflash_cmd.sv
module sflash_cmd
  import sflash_pkg::*;
#(
  parameter int unsigned AW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [AW-1:0]     ld_addr,
  input  logic [WORD_W-1:0] ld_data,
  input  logic              cmd_valid,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic              launch,
  input  logic              viol_clr,
  input  logic              busy,
  output logic [AW-1:0]     addr_q,
  output logic [WORD_W-1:0] data_q,
  output logic [CODE_W-1:0] cmd_q,
  output logic              start,
  output logic              cmd_viol
);
  logic              accept;
  logic              hit;
  logic              ld_en, cmd_en, viol_en;
  logic [CODE_W-1:0] cmd_d;
  logic              viol_d;

  always_comb begin
    accept  = !busy;
    start   = launch && accept;
    ld_en   = ld_valid && accept;
    cmd_en  = start || (cmd_valid && accept);
    cmd_d   = start ? CODE_NONE : cmd_code;
    hit     = busy && (ld_valid || cmd_valid || launch);
    viol_en = hit || viol_clr;
    viol_d  = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      data_q   <= '1;
      cmd_q    <= CODE_NONE;
      cmd_viol <= 1'b0;
    end else begin
      if (ld_en) begin
        addr_q <= ld_addr;
        data_q <= ld_data;
      end
      if (cmd_en)  cmd_q    <= cmd_d;
      if (viol_en) cmd_viol <= viol_d;
    end
  end
endmodule

// File: rtl/sflash_seq.sv
module sflash_seq
  import sflash_pkg::*;
#(
  parameter int unsigned OP_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] cmd_q,
  input  logic              tgt_erased,
  output logic              busy,
  output logic              commit,
  output op_e               op_kind,
  output logic              acc_err
);
  localparam int unsigned CNT_W = (OP_CYCLES > 1) ? $clog2(OP_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(OP_CYCLES - 1);

  op_e              op_q, op_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             err_d;

  always_comb begin
    op_d   = op_q;
    cnt_d  = cnt_q;
    err_d  = acc_err;
    commit = 1'b0;
    if (op_q == OP_IDLE) begin
      if (start) begin
        err_d = 1'b1;
        unique case (cmd_q)
          CODE_ERASE: begin
            op_d  = OP_ERASE;
            cnt_d = CNT_LOAD;
            err_d = 1'b0;
          end
          CODE_PROG: begin
            if (tgt_erased) begin
              op_d  = OP_PROG;
              cnt_d = CNT_LOAD;
              err_d = 1'b0;
            end
          end
          default: err_d = 1'b1;
        endcase
      end
    end else if (cnt_q == '0) begin
      op_d   = OP_IDLE;
      commit = 1'b1;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_IDLE;
      cnt_q   <= '0;
      acc_err <= 1'b0;
    end else begin
      op_q    <= op_d;
      cnt_q   <= cnt_d;
      acc_err <= err_d;
    end
  end

  assign busy    = (op_q != OP_IDLE);
  assign op_kind = op_q;
endmodule

// File: rtl/sflash_store.sv
module sflash_store
  import sflash_pkg::*;
#(
  parameter int unsigned AW          = 11,
  parameter int unsigned NUM_SECTORS = 4,
  parameter logic [WORD_W-1:0] DUMMY = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  op_e               op_kind,
  input  logic [AW-1:0]     op_addr,
  input  logic [WORD_W-1:0] op_data,
  input  logic              busy,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              tgt_erased
);
  localparam int unsigned SW     = SECT_SHIFT;
  localparam int unsigned SECT_W = AW - SW;

  logic [WORD_W-1:0] rd_word  [NUM_SECTORS];
  logic [WORD_W-1:0] chk_word [NUM_SECTORS];
  logic [SECT_W-1:0] op_sect, rd_sect;
  logic [WORD_W-1:0] rd_d;

  assign op_sect = op_addr[AW-1:SW];
  assign rd_sect = rd_addr[AW-1:SW];

  for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_sector
    logic [WORD_W-1:0] bank [WORDS_PER_SECTOR];
    logic              sel;
    assign sel = commit && (op_sect == SECT_W'(s));

    always_ff @(posedge clk) begin
      if (sel) begin
        if (op_kind == OP_ERASE) begin
          for (int w = 0; w < WORDS_PER_SECTOR; w++) bank[w] <= '1;
        end else begin
          bank[op_addr[SW-1:0]] <= op_data;
        end
      end
    end

    assign rd_word[s]  = bank[rd_addr[SW-1:0]];
    assign chk_word[s] = bank[op_addr[SW-1:0]];
  end

  always_comb begin
    tgt_erased = (chk_word[op_sect] == '1);
    rd_d       = (busy && (rd_sect == op_sect)) ? DUMMY : rd_word[rd_sect];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_d;
  end
endmodule

// File: rtl/sector_flash.sv
module sector_flash
  import sflash_pkg::*;
#(
  parameter int unsigned ARRAY_KB  = 4,
  parameter int unsigned OP_CYCLES = 8,
  localparam int unsigned NUM_WORDS   = ARRAY_KB * 1024 / (WORD_W / 8),
  localparam int unsigned NUM_SECTORS = ARRAY_KB * 1024 / SECTOR_BYTES,
  localparam int unsigned ADDR_W      = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [WORD_W-1:0] ld_data,
  input  logic              cmd_valid,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic              launch,
  input  logic              viol_clr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              busy,
  output logic              acc_err,
  output logic              cmd_viol
);
  logic [ADDR_W-1:0]            addr_q;
  logic [WORD_W-1:0]            data_q;
  logic [CODE_W-1:0]            cmd_q;
  logic                         start;
  logic                         commit;
  logic                         tgt_erased;
  op_e                          op_kind;
  logic [ADDR_W-SECT_SHIFT-1:0] op_sector;

  assign op_sector = addr_q[ADDR_W-1:SECT_SHIFT];

  sflash_cmd #(.AW(ADDR_W)) u_cmd (
    .clk, .rst_n, .ld_valid, .ld_addr, .ld_data, .cmd_valid, .cmd_code,
    .launch, .viol_clr, .busy,
    .addr_q, .data_q, .cmd_q, .start, .cmd_viol
  );

  sflash_seq #(.OP_CYCLES(OP_CYCLES)) u_seq (
    .clk, .rst_n, .start, .cmd_q, .tgt_erased,
    .busy, .commit, .op_kind, .acc_err
  );

  sflash_store #(.AW(ADDR_W), .NUM_SECTORS(NUM_SECTORS)) u_store (
    .clk, .rst_n, .commit, .op_kind, .op_addr(addr_q), .op_data(data_q),
    .busy, .rd_addr, .rd_data, .tgt_erased
  );
endmodule

// File: rtl/sector_flash_chk.sv
module sector_flash_chk #(
  parameter int unsigned AW        = 11,
  parameter int unsigned SW        = 9,
  parameter int unsigned OP_CYCLES = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ld_valid,
  input logic          cmd_valid,
  input logic          launch,
  input logic          viol_clr,
  input logic [AW-1:0] rd_addr,
  input logic [15:0]   rd_data,
  input logic          busy,
  input logic          acc_err,
  input logic          cmd_viol,
  input logic [AW-SW-1:0] op_sector
);
  logic [31:0] busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1'b1;
    else           busy_len <= '0;
  end

  a_r6_busy_from_launch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(launch));

  a_r6_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_len == OP_CYCLES));

  a_r5_err_without_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_err) |-> !busy);

  a_r8_viol_on_busy_input: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (launch || ld_valid || cmd_valid)) |=> cmd_viol);

  a_r8_viol_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_viol && !viol_clr) |=> cmd_viol);

  a_r7_dummy_read: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (rd_addr[AW-1:SW] == op_sector)) |=> (rd_data == 16'hFFFF));
endmodule

bind sector_flash sector_flash_chk #(
  .AW(ADDR_W), .SW(sflash_pkg::SECT_SHIFT), .OP_CYCLES(OP_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .cmd_valid(cmd_valid),
  .launch(launch), .viol_clr(viol_clr), .rd_addr(rd_addr), .rd_data(rd_data),
  .busy(busy), .acc_err(acc_err), .cmd_viol(cmd_viol), .op_sector(op_sector)
);

// File: tb/sector_flash_bench.sv
module sector_flash_bench;
  localparam int OPC = 8;
  localparam int AW  = 11;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ld_valid, cmd_valid, launch, viol_clr;
  logic [AW-1:0] ld_addr, rd_addr;
  logic [15:0]   ld_data, rd_data;
  logic [7:0]    cmd_code;
  logic          busy, acc_err, cmd_viol;

  int n_chk  = 0;
  int n_fail = 0;

  logic [15:0] exp_q [$];
  logic [AW-1:0] adr_q [$];
  string       tag_q [$];

  always #10 clk = ~clk;

  sector_flash #(.ARRAY_KB(4), .OP_CYCLES(OPC)) u_sector_flash (
    .clk, .rst_n, .ld_valid, .ld_addr, .ld_data, .cmd_valid, .cmd_code,
    .launch, .viol_clr, .rd_addr, .rd_data, .busy, .acc_err, .cmd_viol
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares the read issued on the previous falling edge
  always @(posedge clk) begin
    if (exp_q.size() > 0) begin
      logic [15:0] e;
      logic [AW-1:0] a;
      string t;
      #1;
      e = exp_q.pop_front();
      a = adr_q.pop_front();
      t = tag_q.pop_front();
      chk($sformatf("%s read @%0d", t, a), {16'h0, rd_data}, {16'h0, e});
    end
  end

  task automatic read_exp(input logic [AW-1:0] a, input logic [15:0] e, input string t);
    @(negedge clk);
    rd_addr = a;
    exp_q.push_back(e);
    adr_q.push_back(a);
    tag_q.push_back(t);
  endtask

  task automatic pulse_ld(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk); ld_valid = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk); ld_valid = 1'b0;
  endtask

  task automatic pulse_cmd(input logic [7:0] c);
    @(negedge clk); cmd_valid = 1'b1; cmd_code = c;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic pulse_launch();
    @(negedge clk); launch = 1'b1;
    @(negedge clk); launch = 1'b0;
  endtask

  task automatic wait_done(input string t);
    int n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
    chk({t, " busy length"}, n, OPC);
  endtask

  task automatic run_op(input logic [AW-1:0] a, input logic [15:0] d,
                        input logic [7:0] c, input string t);
    pulse_ld(a, d);
    pulse_cmd(c);
    pulse_launch();
    wait_done(t);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    ld_valid = 0; cmd_valid = 0; launch = 0; viol_clr = 0;
    ld_addr = '0; ld_data = '0; cmd_code = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 acc_err", acc_err, 0);
    chk("R1 cmd_viol", cmd_viol, 0);

    // erase all four sectors
    for (int s = 0; s < 4; s++) run_op(AW'(s * 512 + 3), 16'h0, 8'h40, "R6 erase");

    // R2: whole sector reads erased
    for (int w = 0; w < 512; w++) read_exp(AW'(512 + w), 16'hFFFF, "R2 erased");

    // R4: program erased words
    run_op(11'd5,   16'h1234, 8'h20, "R4 prog");
    run_op(11'd1024, 16'hA5A5, 8'h20, "R4 prog");
    run_op(11'd600, 16'h0F0F, 8'h20, "R4 prog");
    run_op(11'd511, 16'h00FF, 8'h20, "R4 prog");
    run_op(11'd512, 16'hBEEF, 8'h20, "R4 prog");
    read_exp(11'd5, 16'h1234, "R4");
    read_exp(11'd1024, 16'hA5A5, "R4");
    read_exp(11'd600, 16'h0F0F, "R4");

    // R2/R3: erase sector 1 through an inner address
    run_op(11'd589, 16'h0, 8'h40, "R2 erase");
    read_exp(11'd600, 16'hFFFF, "R2");
    read_exp(11'd512, 16'hFFFF, "R2");
    read_exp(11'd1023, 16'hFFFF, "R2");
    read_exp(11'd5, 16'h1234, "R3 neighbour");
    read_exp(11'd511, 16'h00FF, "R3 neighbour");
    read_exp(11'd1024, 16'hA5A5, "R3 neighbour");

    // R5: reprogram refused
    pulse_ld(11'd5, 16'h0000);
    pulse_cmd(8'h20);
    pulse_launch();
    chk("R5 acc_err", acc_err, 1);
    chk("R5 busy", busy, 0);
    read_exp(11'd5, 16'h1234, "R5 unchanged");

    // R9: unknown code, then valid op clears error
    pulse_cmd(8'h33);
    pulse_launch();
    chk("R9 acc_err", acc_err, 1);
    chk("R9 busy", busy, 0);
    pulse_ld(11'd6, 16'h5555);
    pulse_cmd(8'h20);
    pulse_launch();
    chk("R9 acc_err cleared", acc_err, 0);
    // R7: reads during busy
    read_exp(11'd5, 16'hFFFF, "R7 same sector");
    read_exp(11'd1024, 16'hA5A5, "R7 other sector");
    read_exp(11'd6, 16'hFFFF, "R7 target");
    while (busy) @(negedge clk);
    read_exp(11'd6, 16'h5555, "R6 commit");
    read_exp(11'd5, 16'h1234, "R7 after busy");

    // R10: launch with no fresh command
    pulse_launch();
    chk("R10 acc_err", acc_err, 1);
    chk("R10 busy", busy, 0);

    // R8: inputs during busy are dropped
    pulse_ld(11'd1536, 16'h7777);
    pulse_cmd(8'h40);
    pulse_launch();
    pulse_ld(11'd1600, 16'h1111);
    pulse_cmd(8'h20);
    pulse_launch();
    chk("R8 cmd_viol", cmd_viol, 1);
    while (busy) @(negedge clk);
    pulse_launch();
    chk("R8 cmd ignored", acc_err, 1);
    pulse_cmd(8'h20);
    pulse_launch();
    wait_done("R8 prog");
    read_exp(11'd1536, 16'h7777, "R8 addr kept");
    read_exp(11'd1600, 16'hFFFF, "R8 load ignored");
    chk("R8 still set", cmd_viol, 1);
    @(negedge clk); viol_clr = 1'b1;
    @(negedge clk); viol_clr = 1'b0;
    chk("R8 cleared", cmd_viol, 0);

    // R3 boundary: erase sector 0 via its last word
    run_op(11'd511, 16'h0, 8'h40, "R3 erase");
    read_exp(11'd511, 16'hFFFF, "R2 boundary");
    read_exp(11'd5, 16'hFFFF, "R2 boundary");
    read_exp(11'd512, 16'hFFFF, "R3 boundary");
    read_exp(11'd1024, 16'hA5A5, "R3 boundary");
    read_exp(11'd1536, 16'h7777, "R3 boundary");

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule